// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address sequence that a synchronous memory array walks through during a burst read. The host pulses an address strobe while the chip is selected, and the block captures the start address and the burst mode. From then on, every active clock edge moves the address one word forward. The block stops stepping when the chip is deselected. A new burst always needs a fresh strobe.

There are four burst modes. The continuous mode counts straight up through the whole array and rolls over from the top address to zero. The three wrap modes keep the address inside the naturally aligned 8-, 16- or 32-word group that holds the start address. In these modes the upper address bits never change and only the low group bits count. A configuration input chooses whether the rising or the falling clock edge is the active edge.

Top module: `brst_seq`

## Requirements
- R1: While `rst_n` is low, `word_addr` is 0 and `burst_active` is 0.
- R2: An active edge with `sel_n` low and `addr_strobe` high loads `start_addr` into `word_addr` and sets `burst_active` to 1 from that edge on.
- R3: With `burst_mode` captured as 2'b00 (continuous), `word_addr` rises by one on each active edge after the loading edge.
- R4: In continuous mode, the all-ones address is followed by address 0 and the burst goes on.
- R5: With mode 2'b01 captured, bits [2:0] count modulo 8 and all higher bits stay fixed.
- R6: With mode 2'b10 captured, bits [3:0] count modulo 16 and all higher bits stay fixed.
- R7: With mode 2'b11 captured, bits [4:0] count modulo 32 and all higher bits stay fixed.
- R8: When `sel_n` is high, `burst_active` is 0 in the same cycle, before any clock edge. `word_addr` holds its value on every edge while `sel_n` is high, and a strobe in that time is ignored.
- R9: After a deselect, pulling `sel_n` low again without a strobe leaves `word_addr` frozen and `burst_active` at 0.
- R10: The mode is sampled only on the loading edge. Changing `burst_mode` during a burst does not alter the stepping.
- R11: With `fall_sel` at 1 (held steady across reset), state changes only on falling clock edges. With `fall_sel` at 0, state changes only on rising edges.
- R12: A strobe during a running burst restarts it at the new `start_addr` with the newly sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fall_sel | input | 1 | 1: falling edge is active, 0: rising edge is active |
| sel_n | input | 1 | Chip select, active low; high ends the burst |
| addr_strobe | input | 1 | Start-address capture pulse |
| start_addr | input | ADDR_W | Burst start word address |
| burst_mode | input | 2 | 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| word_addr | output | ADDR_W | Current word address |
| burst_active | output | 1 | Burst running and chip selected |

## Verification
A corrupted address register or group mask shows on `word_addr` at the very next active edge. It appears either as a jump that is not +1 within the group, or as an upper bit that changes in a wrap mode. A run flag or captured mode that has gone wrong cannot hide for long either. The first edge after it would have stepped, frozen or wrapped shows a wrong address, and a run flag stuck high also shows on `burst_active` after a deselect. The reference model is compared after every active edge and again just before it, so any divergence is reported within one clock.

// File: rtl/brst_pkg.sv
package brst_pkg;
   typedef enum logic [1:0] {
      BM_LINEAR = 2'b00,
      BM_WRAP8  = 2'b01,
      BM_WRAP16 = 2'b10,
      BM_WRAP32 = 2'b11
   } brst_mode_e;
endpackage

// File: rtl/brst_edge_pick.sv
// Derives the stepping clock: the true clock or its inverse.
module brst_edge_pick (
   input  logic clk,
   input  logic fall_sel,
   output logic step_clk
);
   assign step_clk = clk ^ fall_sel;
endmodule

// File: rtl/brst_wrap_mask.sv
// Per-bit mask of the address bits that are allowed to count.
module brst_wrap_mask
   import brst_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int GRP_LOG_MIN = 3
) (
   input  brst_mode_e          mode,
   output logic [ADDR_W-1:0]   mask
);
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < GRP_LOG_MIN) begin : g_always
         assign mask[i] = 1'b1;
      end else if (i == GRP_LOG_MIN) begin : g_mid
         assign mask[i] = (mode != BM_WRAP8);
      end else if (i == GRP_LOG_MIN + 1) begin : g_top
         assign mask[i] = (mode == BM_LINEAR) || (mode == BM_WRAP32);
      end else begin : g_upper
         assign mask[i] = (mode == BM_LINEAR);
      end
   end
endmodule

// File: rtl/brst_addr_step.sv
// Next address: masked bits count, unmasked bits are kept.
module brst_addr_step #(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] mask,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] inc;
   assign inc = cur + ADDR_W'(1);
   assign nxt = (cur & ~mask) | (inc & mask);
endmodule

// File: rtl/brst_ctrl.sv
// Burst state registers: run flag, address, captured mode.
module brst_ctrl
   import brst_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              step_clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              addr_strobe,
   input  logic [ADDR_W-1:0] start_addr,
   input  brst_mode_e        mode_in,
   input  logic [ADDR_W-1:0] nxt_addr,
   output logic              run_q,
   output logic [ADDR_W-1:0] addr_q,
   output brst_mode_e        mode_q
);
   always_ff @(posedge step_clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         addr_q <= '0;
         mode_q <= BM_LINEAR;
      end else if (sel_n) begin
         run_q  <= 1'b0;
      end else if (addr_strobe) begin
         run_q  <= 1'b1;
         addr_q <= start_addr;
         mode_q <= mode_in;
      end else if (run_q) begin
         addr_q <= nxt_addr;
      end
   end
endmodule

// File: rtl/brst_seq.sv
module brst_seq
   import brst_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int GRP_LOG_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_sel,
   input  logic              sel_n,
   input  logic              addr_strobe,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        burst_mode,
   output logic [ADDR_W-1:0] word_addr,
   output logic              burst_active
);
   localparam int GRP_LOG_MAX = GRP_LOG_MIN + 2;

   if (GRP_LOG_MIN < 1) begin : g_bad_min
      $error("brst_seq: GRP_LOG_MIN must be at least 1");
   end
   if (ADDR_W <= GRP_LOG_MAX) begin : g_bad_w
      $error("brst_seq: ADDR_W must exceed the largest group width");
   end

   logic              step_clk;
   logic              run_q;
   brst_mode_e        mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] cnt_mask;
   logic [ADDR_W-1:0] nxt_addr;

   brst_edge_pick u_edge (
      .clk      (clk),
      .fall_sel (fall_sel),
      .step_clk (step_clk)
   );

   brst_wrap_mask #(.ADDR_W(ADDR_W), .GRP_LOG_MIN(GRP_LOG_MIN)) u_mask (
      .mode (mode_q),
      .mask (cnt_mask)
   );

   brst_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur  (addr_q),
      .mask (cnt_mask),
      .nxt  (nxt_addr)
   );

   brst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .step_clk    (step_clk),
      .rst_n       (rst_n),
      .sel_n       (sel_n),
      .addr_strobe (addr_strobe),
      .start_addr  (start_addr),
      .mode_in     (brst_mode_e'(burst_mode)),
      .nxt_addr    (nxt_addr),
      .run_q       (run_q),
      .addr_q      (addr_q),
      .mode_q      (mode_q)
   );

   assign word_addr    = addr_q;
   assign burst_active = run_q & ~sel_n;
endmodule

// File: rtl/brst_seq_chk.sv
module brst_seq_chk #(
   parameter int ADDR_W      = 12,
   parameter int GRP_LOG_MIN = 3
) (
   input logic              step_clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              addr_strobe,
   input logic [ADDR_W-1:0] start_addr,
   input logic [ADDR_W-1:0] word_addr,
   input logic              run_q,
   input logic [1:0]        mode_q
);
   localparam int HI_LSB = GRP_LOG_MIN + 2;

   // R2
   load_start_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      (!sel_n && addr_strobe) |=> (word_addr == $past(start_addr)) && run_q);

   // R8
   hold_desel_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      sel_n |=> (word_addr == $past(word_addr)) && !run_q);

   // R3
   linear_inc_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      (run_q && !sel_n && !addr_strobe && mode_q == 2'b00)
      |=> word_addr == $past(word_addr) + ADDR_W'(1));

   // R5
   wrap_upper_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      (run_q && !sel_n && !addr_strobe && mode_q != 2'b00)
      |=> word_addr[ADDR_W-1:HI_LSB] == $past(word_addr[ADDR_W-1:HI_LSB]));

   // R10
   mode_keep_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      !addr_strobe |=> $stable(mode_q));

   // R9
   idle_freeze_chk: assert property (@(posedge step_clk) disable iff (!rst_n)
      (!run_q && !addr_strobe) |=> $stable(word_addr) && !run_q);
endmodule

bind brst_seq brst_seq_chk #(.ADDR_W(ADDR_W), .GRP_LOG_MIN(GRP_LOG_MIN)) u_chk (
   .step_clk    (step_clk),
   .rst_n       (rst_n),
   .sel_n       (sel_n),
   .addr_strobe (addr_strobe),
   .start_addr  (start_addr),
   .word_addr   (word_addr),
   .run_q       (run_q),
   .mode_q      (mode_q)
);

// File: tb/sim_brst_seq.sv
`timescale 1ns/100ps
module sim_brst_seq;
   localparam int AW   = 12;
   localparam int SPAN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fall_sel = 1'b0;
   logic          sel_n = 1'b1;
   logic          addr_strobe = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [1:0]    burst_mode = 2'b00;
   logic [AW-1:0] word_addr;
   logic          burst_active;

   int n_vec = 0;
   int n_bad = 0;
   int m_addr = 0;
   int m_mode = 0;
   bit m_run  = 1'b0;
   bit done   = 1'b0;
   int seed   = 32'h1234_5677;

   always #2 clk = ~clk;

   brst_seq #(.ADDR_W(AW), .GRP_LOG_MIN(3)) u0 (
      .clk(clk), .rst_n(rst_n), .fall_sel(fall_sel), .sel_n(sel_n),
      .addr_strobe(addr_strobe), .start_addr(start_addr), .burst_mode(burst_mode),
      .word_addr(word_addr), .burst_active(burst_active)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic wait_active;
      if (fall_sel) @(negedge clk); else @(posedge clk);
   endtask

   // Apply inputs, check before the edge, update the model at the edge, check after it.
   task automatic step(input bit sn, input bit st, input int a, input int md, input string req);
      int g;
      sel_n = sn; addr_strobe = st; start_addr = AW'(a); burst_mode = 2'(md);
      #0.5;
      chk(req, int'(burst_active), int'(m_run && !sn), "active before edge");
      wait_active();
      if (sn) m_run = 1'b0;
      else if (st) begin m_addr = a; m_run = 1'b1; m_mode = md; end
      else if (m_run) begin
         g = (m_mode == 0) ? SPAN : (8 << (m_mode - 1));
         m_addr = (m_addr / g) * g + ((m_addr % g) + 1) % g;
      end
      #1;
      chk(req, int'(word_addr), m_addr, "address");
      chk(req, int'(burst_active), int'(m_run && !sn), "active");
   endtask

   task automatic do_reset(input bit fs);
      rst_n = 1'b0; sel_n = 1'b1; addr_strobe = 1'b0;
      fall_sel = fs;
      m_run = 1'b0; m_addr = 0; m_mode = 0;
      #9;
      // R1
      chk("R1", int'(word_addr), 0, "reset address");
      chk("R1", int'(burst_active), 0, "reset active");
      rst_n = 1'b1;
      wait_active(); #1;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);
      // R2 / R3 / R4: continuous burst across the top of the array
      step(0, 1, 'hFFB, 0, "R2");
      for (int i = 0; i < 9; i++) step(0, 0, 0, 0, "R4");
      step(0, 1, 'h101, 0, "R2");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R3");
      // R5: wrap 8
      step(0, 1, 'h0D5, 1, "R2");
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, "R5");
      // R6: wrap 16
      step(0, 1, 'h13C, 2, "R2");
      for (int i = 0; i < 18; i++) step(0, 0, 0, 2, "R6");
      // R7: wrap 32, with mode input toggling (R10)
      step(0, 1, 'h3FB, 3, "R2");
      for (int i = 0; i < 34; i++) step(0, 0, 0, i % 4, "R7");
      // R10: burst captured as wrap 8, input switched to continuous
      step(0, 1, 'h7FE, 1, "R2");
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R10");
      // R12: restart mid-burst
      step(0, 1, 'h23A, 2, "R12");
      step(0, 0, 0, 2, "R12");
      step(0, 1, 'h51F, 0, "R12");
      step(0, 0, 0, 3, "R12");
      // R8: deselect clears active at once, holds address, ignores strobe
      step(1, 0, 0, 0, "R8");
      step(1, 1, 'h777, 3, "R8");
      step(1, 0, 0, 0, "R8");
      // R9: reselect without strobe stays frozen
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R9");
      step(0, 1, 'h00F, 1, "R2");
      step(0, 0, 0, 1, "R5");
      // mixed stimulus
      for (int i = 0; i < 400; i++) begin
         seed = seed * 1103515245 + 12345;
         step(((seed >>> 20) & 15) == 0, ((seed >>> 16) & 15) == 0,
              (seed >>> 4) & (SPAN - 1), (seed >>> 24) & 3, "R3");
      end

      // R11: falling edge active
      do_reset(1'b1);
      step(0, 1, 'h0E6, 1, "R11");
      for (int i = 0; i < 5; i++) begin
         step(0, 0, 0, 1, "R11");
         @(posedge clk); #0.5;
         chk("R11", int'(word_addr), m_addr, "no change on rising edge");
      end
      step(0, 1, 'hFFE, 0, "R11");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, "R8");
      step(0, 0, 0, 0, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule